// File: doc/BRIEF.md
# Two-Phase Permutation Scheduler for a Dual-Complete-Graph Bus Network

This block schedules a total permutation on a hypernetwork of `N_BUS` shared buses and `N_BUS(N_BUS-1)/2` processors. Each processor sits on exactly two buses. Processor `<l,u>`, with `1 <= l < u <= N_BUS`, is attached to bus `l` (its lower bus) and bus `u` (its upper bus). Software fills a table with one destination for each source processor and then pulses start. The scheduler checks that the table is a bijection and finds a path of one or two hops for every message. It then plays out a stream of synchronous bus slots. In each slot every bus carries at most one transfer, and that transfer is given as a hop source, a hop destination and the tag of the original sender.

The route depends only on the upper labels of the two ends of the message. If both ends share an upper bus, the message makes one hop on that bus. Otherwise the first hop uses the source's upper bus and ends at the processor that joins the two upper buses. The second hop then uses the destination's upper bus. All first hops run before any second hop, so each phase needs at most `N_BUS-1` slots.

Top module: `kdual_perm_sched`

## Requirements
- R1: Processor flat index is `p = (u-1)(u-2)/2 + (l-1)` for pair `<l,u>`. Lane `k` of every per-bus output belongs to bus `k+1`. All src, dst and tag fields are flat indices.
- R2: A message whose source and destination share an upper label `b` is sent in phase 1 as a single transfer on bus `b`, directly to its destination, and has no phase-2 hop.
- R3: A message from upper `b` to upper `b'`, with `b < b'`, goes in phase 1 on bus `b` to processor `<b,b'>`. In phase 2 it goes on bus `b'` from `<b,b'>` to the destination.
- R4: A message from upper `b` to upper `b'`, with `b > b'`, goes in phase 1 on bus `b` to processor `<b',b>`. In phase 2 it goes on bus `b'` from `<b',b>` to the destination.
- R5: A source that maps to itself produces no transfer. A hop whose two ends are the same processor is not issued.
- R6: `phase_o` is 0 during phase-1 slots and 1 during phase-2 slots. No phase-1 slot follows a phase-2 slot. Slots are issued on consecutive cycles, starting the cycle after start is accepted.
- R7: Each bus carries at most one transfer per slot, and bus 1 (lane 0) is never used. A run uses at most `2(N_BUS-1)` slots.
- R8: In phase 1, each bus serves its pending hops in ascending order of source flat index.
- R9: In phase 2, each bus serves its pending hops by the phase-1 slot in which the message reached its intermediate processor. A skipped first hop counts as slot 0. Ties go to the lower tag.
- R10: If the table is not a bijection onto `0..NP-1` at start, no slot is issued. `done_o` pulses in the next cycle and `err_o` rises with it and stays high until the next start.
- R11: `done_o` is high for exactly one cycle, in the cycle after the last slot, or in the cycle after start if there are no slots. `slot_cnt_o` then equals the number of slots and holds until the next start.
- R12: After reset the table is the identity. Table writes (`load_en_i`) are taken only while the scheduler is idle and are ignored during a run.
- R13: After reset, `slot_vld_o`, `xfer_vld_o`, `done_o`, `err_o` and `slot_cnt_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_en_i | input | 1 | Write one table entry (idle only) |
| load_src_i | input | IW | Source processor flat index |
| load_dst_i | input | IW | Destination processor flat index |
| start_i | input | 1 | Begin scheduling the loaded table |
| slot_vld_o | output | 1 | A bus slot is being issued this cycle |
| phase_o | output | 1 | 0 = first-hop phase, 1 = second-hop phase |
| xfer_vld_o | output | N_BUS | Per-bus transfer valid, lane k = bus k+1 |
| xfer_src_o | output | N_BUS x IW | Per-bus hop source |
| xfer_dst_o | output | N_BUS x IW | Per-bus hop destination |
| xfer_tag_o | output | N_BUS x IW | Per-bus original sender of the message |
| done_o | output | 1 | One-cycle end-of-run pulse |
| err_o | output | 1 | Table was not a bijection |
| slot_cnt_o | output | CW | Slots used in the current or last run |

## Verification
A corrupted pending bit or delivery-slot record has one of three results at the ports. A hop is dropped, repeated, or moved to another slot, and the scoreboard sees this in the first lane comparison after the fault, within one slot. A wrong label decode puts a transfer on the wrong lane or gives it a wrong intermediate. The next transfer that message makes shows the error. A fault in the phase switch or the end-of-run logic moves `done_o` off its expected cycle or changes `slot_cnt_o`. These are checked in the cycle after the last slot of each run.

// File: rtl/kdual_pkg.sv
`timescale 1ns/1ps
package kdual_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FAIL} sched_st_e;

  // flat processor index of pair <lo,up>, 1 <= lo < up
  function automatic int pair_flat(int lo, int up);
    return (up - 1) * (up - 2) / 2 + lo - 1;
  endfunction
endpackage

// File: rtl/kdual_label_map.sv
`timescale 1ns/1ps
module kdual_label_map #(
  parameter int NB = 6,
  parameter int NP = 15,
  parameter int BW = 3
) (
  output logic [NP-1:0][BW-1:0] up_o
);
  always_comb begin
    up_o = '0;
    for (int u = 2; u <= NB; u++) begin
      for (int l = 1; l < u; l++) begin
        up_o[kdual_pkg::pair_flat(l, u)] = BW'(u);
      end
    end
  end
endmodule

// File: rtl/kdual_bij_check.sv
`timescale 1ns/1ps
module kdual_bij_check #(
  parameter int NP = 15,
  parameter int IW = 4
) (
  input  logic [NP-1:0][IW-1:0] map_i,
  output logic                  bij_o
);
  logic [NP-1:0] hit;

  // NP entries cover NP targets exactly when every target is hit
  always_comb begin
    hit = '0;
    for (int i = 0; i < NP; i++) begin
      if (int'(map_i[i]) < NP) hit[map_i[i]] = 1'b1;
    end
    bij_o = &hit;
  end
endmodule

// File: rtl/kdual_min_pick.sv
`timescale 1ns/1ps
module kdual_min_pick #(
  parameter int NP = 15,
  parameter int IW = 4,
  parameter int KW = 4
) (
  input  logic [NP-1:0]         req_i,
  input  logic [NP-1:0][KW-1:0] key_i,
  output logic                  vld_o,
  output logic [IW-1:0]         idx_o
);
  logic          found;
  logic [KW-1:0] best;

  // smallest key wins; strict compare keeps the lowest index on ties
  always_comb begin
    found = 1'b0;
    best  = '0;
    idx_o = '0;
    for (int i = 0; i < NP; i++) begin
      if (req_i[i] && (!found || key_i[i] < best)) begin
        found = 1'b1;
        best  = key_i[i];
        idx_o = IW'(i);
      end
    end
    vld_o = found;
  end
endmodule

// File: rtl/kdual_perm_sched.sv
`timescale 1ns/1ps
module kdual_perm_sched #(
  parameter int N_BUS = 6,
  localparam int NP = N_BUS * (N_BUS - 1) / 2,
  localparam int IW = $clog2(NP),
  localparam int BW = $clog2(N_BUS + 1),
  localparam int CW = $clog2(2 * N_BUS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      load_en_i,
  input  logic [IW-1:0]             load_src_i,
  input  logic [IW-1:0]             load_dst_i,
  input  logic                      start_i,
  output logic                      slot_vld_o,
  output logic                      phase_o,
  output logic [N_BUS-1:0]          xfer_vld_o,
  output logic [N_BUS-1:0][IW-1:0]  xfer_src_o,
  output logic [N_BUS-1:0][IW-1:0]  xfer_dst_o,
  output logic [N_BUS-1:0][IW-1:0]  xfer_tag_o,
  output logic                      done_o,
  output logic                      err_o,
  output logic [CW-1:0]             slot_cnt_o
);
  import kdual_pkg::*;

  sched_st_e               st_q;
  logic [NP-1:0][IW-1:0]   tbl_q;
  logic [NP-1:0]           p1_q, p2_q;
  logic [NP-1:0][CW-1:0]   dsl_q;
  logic [CW-1:0]           cnt_q;
  logic                    err_q;

  logic [NP-1:0][BW-1:0]   up_w, dup_w;
  logic [NP-1:0][IW-1:0]   mid_w, h1d_w;
  logic [NP-1:0]           h1_w, h2_w;
  logic                    bij_w;
  logic                    run_w, ph1_w, ph2_w, slot_w;

  wire [N_BUS-1:0]          lane_v;
  wire [N_BUS-1:0][IW-1:0]  lane_g, lane_s, lane_d;

  kdual_label_map #(.NB(N_BUS), .NP(NP), .BW(BW)) u_lbl (.up_o(up_w));
  kdual_bij_check #(.NP(NP), .IW(IW)) u_chk (.map_i(tbl_q), .bij_o(bij_w));

  // route of each message, from source and destination upper labels
  always_comb begin
    for (int i = 0; i < NP; i++) begin
      logic [IW-1:0] d, ds;
      logic [BW-1:0] b, bd, mn, mx;
      logic          one, mv;
      d  = tbl_q[i];
      ds = (int'(d) < NP) ? d : '0;
      b  = up_w[i];
      bd = up_w[ds];
      mn = (b < bd) ? b : bd;
      mx = (b < bd) ? bd : b;
      one = (b == bd);
      mv  = (d != IW'(i));
      mid_w[i] = IW'(pair_flat(int'(mn), int'(mx)));
      h1d_w[i] = one ? d : mid_w[i];
      h1_w[i]  = mv && (h1d_w[i] != IW'(i));
      h2_w[i]  = mv && !one && (mid_w[i] != d);
      dup_w[i] = bd;
    end
  end

  assign run_w  = (st_q == ST_RUN);
  assign ph1_w  = run_w && (|p1_q);
  assign ph2_w  = run_w && !(|p1_q) && (|p2_q);
  assign slot_w = ph1_w || ph2_w;

  for (genvar k = 0; k < N_BUS; k++) begin : g_bus
    logic [NP-1:0]         req;
    logic [NP-1:0][CW-1:0] key;
    logic                  gv;
    logic [IW-1:0]         gi;

    always_comb begin
      for (int i = 0; i < NP; i++) begin
        req[i] = ph1_w ? (p1_q[i] && up_w[i] == BW'(k + 1))
                       : (ph2_w && p2_q[i] && dup_w[i] == BW'(k + 1));
        key[i] = ph1_w ? '0 : dsl_q[i];
      end
    end

    kdual_min_pick #(.NP(NP), .IW(IW), .KW(CW)) u_pick (
      .req_i(req), .key_i(key), .vld_o(gv), .idx_o(gi)
    );

    assign lane_v[k] = gv;
    assign lane_g[k] = gi;
    assign lane_s[k] = ph1_w ? gi : mid_w[gi];
    assign lane_d[k] = ph1_w ? h1d_w[gi] : tbl_q[gi];

    assert_pick_req_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gv |-> req[gi]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      p1_q  <= '0;
      p2_q  <= '0;
      dsl_q <= '0;
      cnt_q <= '0;
      err_q <= 1'b0;
      for (int i = 0; i < NP; i++) tbl_q[i] <= IW'(i);
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (load_en_i && int'(load_src_i) < NP) tbl_q[load_src_i] <= load_dst_i;
          if (start_i) begin
            cnt_q <= '0;
            if (bij_w) begin
              st_q  <= ST_RUN;
              p1_q  <= h1_w;
              p2_q  <= h2_w;
              dsl_q <= '0;
              err_q <= 1'b0;
            end else begin
              st_q  <= ST_FAIL;
              err_q <= 1'b1;
            end
          end
        end
        ST_RUN: begin
          if (slot_w) begin
            cnt_q <= cnt_q + 1'b1;
            for (int k = 0; k < N_BUS; k++) begin
              if (lane_v[k]) begin
                if (ph1_w) begin
                  p1_q[lane_g[k]]  <= 1'b0;
                  dsl_q[lane_g[k]] <= cnt_q;
                end else begin
                  p2_q[lane_g[k]] <= 1'b0;
                end
              end
            end
          end else begin
            st_q <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign slot_vld_o = slot_w;
  assign phase_o    = ph2_w;
  assign xfer_vld_o = lane_v;
  assign xfer_tag_o = lane_g;
  assign xfer_src_o = lane_s;
  assign xfer_dst_o = lane_d;
  assign done_o     = (run_w && !slot_w) || (st_q == ST_FAIL);
  assign err_o      = err_q;
  assign slot_cnt_o = cnt_q;

  assert_bus1_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xfer_vld_o[0]);
  assert_slot_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_vld_o |-> (int'(slot_cnt_o) < 2 * (N_BUS - 1)));
  assert_phase_order_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_vld_o && phase_o) |=> !(slot_vld_o && !phase_o));
  assert_done_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_err_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !slot_vld_o);
  assert_load_ignored_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE) |=> $stable(tbl_q));
endmodule

// File: tb/sim_kdual_perm_sched.sv
`timescale 1ns/1ps
module sim_kdual_perm_sched;
  localparam int NB = 6;
  localparam int NP = NB * (NB - 1) / 2;
  localparam int IW = $clog2(NP);
  localparam int CW = $clog2(2 * NB);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic                  load_en = 1'b0;
  logic [IW-1:0]         load_src = '0, load_dst = '0;
  logic                  start = 1'b0;
  logic                  slot_vld, phase, done, err;
  logic [NB-1:0]         xv;
  logic [NB-1:0][IW-1:0] xs, xd, xt;
  logic [CW-1:0]         scnt;

  kdual_perm_sched #(.N_BUS(NB)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .load_en_i(load_en), .load_src_i(load_src),
    .load_dst_i(load_dst), .start_i(start), .slot_vld_o(slot_vld), .phase_o(phase),
    .xfer_vld_o(xv), .xfer_src_o(xs), .xfer_dst_o(xd), .xfer_tag_o(xt),
    .done_o(done), .err_o(err), .slot_cnt_o(scnt)
  );

  typedef struct {int slot; int bus; int src; int dst; int tag; int ph; string req;} xfer_t;
  xfer_t exp_q[$];
  xfer_t it;
  int  perm[NP];
  int  nvec = 0, nfail = 0;
  int  exp_slots;
  bit  exp_err;
  bit  mon_on = 0, done_seen, err_seen;
  int  mon_k, done_k;
  int unsigned seed = 32'h1234_5678;

  function automatic int flat(int l, int u);
    return (u - 1) * (u - 2) / 2 + l - 1;
  endfunction

  function automatic int up_of(int p);
    for (int u = 2; u <= NB; u++)
      for (int l = 1; l < u; l++)
        if (flat(l, u) == p) return u;
    return 0;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  // reference schedule from the requirements
  task automatic build();
    int h1d[NP], mid[NP], dl[NP];
    bit p1[NP], p2[NP];
    int s;
    exp_q.delete();
    for (int i = 0; i < NP; i++) begin
      int b, bd, d;
      d = perm[i]; b = up_of(i); bd = up_of(d);
      mid[i] = (b < bd) ? flat(b, bd) : flat(bd, b);
      h1d[i] = (b == bd) ? d : mid[i];
      p1[i]  = (d != i) && (h1d[i] != i);
      p2[i]  = (d != i) && (b != bd) && (mid[i] != d);
      dl[i]  = 0;
    end
    s = 0;
    forever begin
      bit any = 0;
      for (int bus = 2; bus <= NB; bus++) begin
        int pick = -1;
        for (int i = 0; i < NP; i++)
          if (pick < 0 && p1[i] && up_of(i) == bus) pick = i;
        if (pick >= 0) begin
          int b = up_of(pick), bd = up_of(perm[pick]);
          string rq = (b == bd) ? "R2 R8" : ((b < bd) ? "R3 R8" : "R4 R8");
          exp_q.push_back('{s, bus, pick, h1d[pick], pick, 0, rq});
          p1[pick] = 0; dl[pick] = s; any = 1;
        end
      end
      if (!any) break;
      s++;
    end
    forever begin
      bit any = 0;
      for (int bus = 2; bus <= NB; bus++) begin
        int pick = -1;
        for (int i = 0; i < NP; i++)
          if (p2[i] && up_of(perm[i]) == bus)
            if (pick < 0 || dl[i] < dl[pick]) pick = i;
        if (pick >= 0) begin
          string rq = (up_of(pick) < bus) ? "R3 R9" : "R4 R9";
          exp_q.push_back('{s, bus, mid[pick], perm[pick], pick, 1, rq});
          p2[pick] = 0; any = 1;
        end
      end
      if (!any) break;
      s++;
    end
    exp_slots = s;
  endtask

  // monitor: pops expected transfers lane by lane
  always @(negedge clk) begin
    if (mon_on) begin
      mon_k++;
      for (int k = 0; k < NB; k++) begin
        if (slot_vld && xv[k]) begin
          if (k == 0) check(0, "R7", "bus 1 lane used", 1, 0);
          if (exp_q.size() == 0) check(0, "R5", "unexpected transfer on bus", k + 1, 0);
          else begin
            it = exp_q.pop_front();
            check(it.bus == k + 1, it.req, "bus", k + 1, it.bus);
            check(it.slot == mon_k - 1, "R6", "slot index", mon_k - 1, it.slot);
            check(int'(phase) == it.ph, "R6", "phase", int'(phase), it.ph);
            check(int'(xs[k]) == it.src, {"R1 ", it.req}, "hop src", int'(xs[k]), it.src);
            check(int'(xd[k]) == it.dst, {"R1 ", it.req}, "hop dst", int'(xd[k]), it.dst);
            check(int'(xt[k]) == it.tag, it.req, "tag", int'(xt[k]), it.tag);
          end
        end
      end
      if (done) begin
        done_seen = 1; done_k = mon_k; err_seen = err; mon_on = 0;
      end else if (!slot_vld) begin
        check(0, "R11", "idle cycle before done", mon_k, exp_slots + 1);
      end
    end
  end

  task automatic load_table();
    for (int i = 0; i < NP; i++) begin
      @(posedge clk); #1;
      load_en = 1; load_src = IW'(i); load_dst = IW'(perm[i]);
    end
    @(posedge clk); #1;
    load_en = 0;
  endtask

  task automatic run(bit do_load, bit poke);
    int t;
    if (do_load) load_table();
    if (exp_err) begin exp_q.delete(); exp_slots = 0; end
    else build();
    @(posedge clk); #1; start = 1;
    @(posedge clk); #1; start = 0;
    done_seen = 0; mon_k = 0; mon_on = 1;
    if (poke) begin
      @(posedge clk); #1; load_en = 1; load_src = '0; load_dst = IW'(7);
      @(posedge clk); #1; load_en = 0;
    end
    t = 0;
    while (!done_seen && t < 1000) begin @(posedge clk); t++; end
    check(done_seen, "R11", "done seen", int'(done_seen), 1);
    check(done_k == exp_slots + 1, "R11", "done cycle", done_k, exp_slots + 1);
    check(done_k - 1 <= 2 * (NB - 1), "R7", "slot count bound", done_k - 1, 2 * (NB - 1));
    @(negedge clk);
    check(int'(scnt) == exp_slots, "R11", "slot count", int'(scnt), exp_slots);
    check(err_seen == exp_err, "R10", "error flag", int'(err_seen), int'(exp_err));
    check(exp_q.size() == 0, "R2", "transfers missing", exp_q.size(), 0);
    mon_on = 0;
  endtask

  task automatic set_identity();
    for (int i = 0; i < NP; i++) perm[i] = i;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL R11 watchdog expired act=%0d exp=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(slot_vld == 0, "R13", "slot_vld after reset", int'(slot_vld), 0);
    check(xv == '0, "R13", "xfer_vld after reset", int'(xv), 0);
    check(done == 0, "R13", "done after reset", int'(done), 0);
    check(err == 0, "R13", "err after reset", int'(err), 0);
    check(scnt == '0, "R13", "slot_cnt after reset", int'(scnt), 0);

    // R12: reset table is identity, so no slots
    exp_err = 0; set_identity(); run(0, 0);

    // R2: swap <1,3> and <2,3>, one hop each on bus 3
    set_identity(); perm[1] = 2; perm[2] = 1; run(1, 0);

    // R5: <1,2> <-> <2,4>, each has one degenerate hop
    set_identity(); perm[0] = 4; perm[4] = 0; run(1, 0);

    // R3 R4: cyclic shift
    for (int i = 0; i < NP; i++) perm[i] = (i + 1) % NP;
    run(1, 0);

    // reverse, then reverse with a write during the run, then rerun (R12)
    for (int i = 0; i < NP; i++) perm[i] = NP - 1 - i;
    run(1, 0);
    run(0, 1);
    run(0, 0);

    // R10: duplicate destination, then out-of-range destination
    exp_err = 1; set_identity(); perm[3] = 5; run(1, 0);
    set_identity(); perm[2] = 15; run(1, 0);
    exp_err = 0;

    // R8 R9: random permutations
    for (int r = 0; r < 6; r++) begin
      set_identity();
      for (int i = NP - 1; i > 0; i--) begin
        int j, tmp;
        seed = seed * 1103515245 + 12345;
        j = int'((seed >> 16) % (i + 1));
        tmp = perm[i]; perm[i] = perm[j]; perm[j] = tmp;
      end
      run(1, 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule